// File: doc/BRIEF.md
# PWM Channel with Selectable Count Clock

This block is one pulse-width-modulation channel. A 16-bit counter advances on a count-enable tick. The tick comes from one of eleven power-of-two taps of a free-running prescaler, or from one of two linear dividers whose divisors are programmable. The counter runs in one of two modes. In left-aligned mode it counts up and wraps. In center-aligned mode it climbs to the period value and falls back to zero, which doubles the output period for the same period setting. A comparator holds the output active while the counter is below the duty value, and a polarity bit flips the sense of the output.

All settings arrive through single-cycle write strobes, each with its own data bus. Period, duty and alignment go to shadow registers. The running channel picks them up only at a period end, so the waveform never changes in the middle of a cycle. A period-end pulse marks each counter cycle.

Top module: `pwm_chan_core`

## Requirements
- R1: After reset the clock select is 0, both divisors, the period, the duty, the alignment and the polarity are 0, `pwm_o` is low and `period_end_o` is low.
- R2: Clock-select codes 0 to 10 make the counter advance once every 2^code master-clock cycles. The tick for code k falls in the cycles where the low k bits of a prescaler (cleared by reset, +1 every cycle) are all ones.
- R3: Code 11 advances the counter once every A cycles and code 12 once every B cycles, where A and B are the written divisors. A divisor of 0 gives no ticks. Writing a divisor restarts that divider's count.
- R4: Codes 13, 14 and 15 freeze the counter and raise no period end.
- R5: In left-aligned mode (alignment 0) with period P > 0 the counter steps 0..P-1 and wraps, so one output cycle takes P ticks. `period_end_o` is high during the tick that wraps the counter to 0.
- R6: In center-aligned mode (alignment 1) with period P > 0 the counter steps 0..P and back down to 0, so one output cycle takes 2P ticks. `period_end_o` is high during the tick that brings the counter down to 0.
- R7: With polarity 0, `pwm_o` is 1 while the counter is below duty D. D = 0 gives a constant 0, and D >= P gives a constant 1.
- R8: A polarity of 1 inverts `pwm_o`. A polarity write takes effect in the next cycle.
- R9: Written period, duty and alignment values reach the running channel only at a period end, including a write made in the same cycle as the period end. While the active period is 0 the channel is idle, raises no event and takes new values on the next cycle.
- R10: A period-end pulse lasts a single master-clock cycle whenever the tick rate is below the clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| sel_we | input | 1 | Clock-select write strobe |
| sel_wd | input | 4 | Clock-select code |
| diva_we | input | 1 | Divisor A write strobe |
| divb_we | input | 1 | Divisor B write strobe |
| div_wd | input | DW | Divisor value |
| per_we | input | 1 | Period write strobe |
| per_wd | input | CW | Period value |
| duty_we | input | 1 | Duty write strobe |
| duty_wd | input | CW | Duty value |
| mode_we | input | 1 | Alignment write strobe |
| center_wd | input | 1 | 1 = center-aligned |
| pol_we | input | 1 | Polarity write strobe |
| pol_wd | input | 1 | 1 = inverted output |
| pwm_o | output | 1 | PWM waveform |
| period_end_o | output | 1 | One-cycle period-end pulse |

## Verification
A period write can land in the same cycle as a period end. When it does, the new value must be loaded at that period end, not one period later. The bench provokes this collision by watching `period_end_o` at the falling edge and issuing the period and duty writes in that same cycle. A behavioural model predicts `pwm_o` and `period_end_o` on every clock, and any difference on the following cycles shows whether the bypass was honoured. A second collision comes from changing the clock select just after a period end, which is judged the same way.

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_we,
  input  logic [3:0]    sel_wd,
  input  logic          diva_we,
  input  logic          divb_we,
  input  logic [DW-1:0] div_wd,
  input  logic          per_we,
  input  logic [CW-1:0] per_wd,
  input  logic          duty_we,
  input  logic [CW-1:0] duty_wd,
  input  logic          mode_we,
  input  logic          center_wd,
  input  logic          pol_we,
  input  logic          pol_wd,
  output logic          pwm_o,
  output logic          period_end_o
);
  localparam int NTAP = 11;
  localparam int PW   = NTAP - 1;

  logic [PW-1:0]   pre;
  logic [NTAP-1:0] taps;
  logic [3:0]      sel_r;
  logic [DW-1:0]   da, db, ca, cb;
  logic [CW-1:0]   per_sh, duty_sh, per_act, duty_act, cnt, nxt;
  logic            mode_sh, mode_act, pol_r, down, nxt_down;
  logic            tick, tick_a, tick_b, idle, load;

  assign taps[0] = 1'b1;
  for (genvar k = 1; k < NTAP; k++) begin : g_tap
    assign taps[k] = &pre[k-1:0];
  end

  assign tick_a = (da != '0) && (ca == da - DW'(1));
  assign tick_b = (db != '0) && (cb == db - DW'(1));

  always_comb begin
    if (sel_r < 4'd11)       tick = taps[sel_r];
    else if (sel_r == 4'd11) tick = tick_a;
    else if (sel_r == 4'd12) tick = tick_b;
    else                     tick = 1'b0;
  end

  always_comb begin
    nxt = cnt;
    nxt_down = down;
    if (per_act == '0) begin
      nxt = '0;
      nxt_down = 1'b0;
    end else if (!mode_act) begin
      nxt = (cnt >= per_act - CW'(1)) ? '0 : cnt + CW'(1);
      nxt_down = 1'b0;
    end else if ((down && cnt != '0) || cnt >= per_act) begin
      nxt = cnt - CW'(1);
      nxt_down = (cnt != CW'(1));
    end else begin
      nxt = cnt + CW'(1);
      nxt_down = 1'b0;
    end
  end

  assign idle         = (per_act == '0);
  assign period_end_o = tick && !idle && (nxt == '0);
  assign load         = period_end_o || idle;
  assign pwm_o        = pol_r ^ ((duty_act != '0) && (duty_act >= per_act || cnt < duty_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; sel_r <= '0; da <= '0; db <= '0; ca <= '0; cb <= '0;
      per_sh <= '0; duty_sh <= '0; mode_sh <= 1'b0; pol_r <= 1'b0;
      per_act <= '0; duty_act <= '0; mode_act <= 1'b0;
      cnt <= '0; down <= 1'b0;
    end else begin
      pre <= pre + PW'(1);
      if (sel_we)  sel_r   <= sel_wd;
      if (diva_we) da      <= div_wd;
      if (divb_we) db      <= div_wd;
      if (per_we)  per_sh  <= per_wd;
      if (duty_we) duty_sh <= duty_wd;
      if (mode_we) mode_sh <= center_wd;
      if (pol_we)  pol_r   <= pol_wd;
      ca <= (diva_we || tick_a || da == '0) ? '0 : ca + DW'(1);
      cb <= (divb_we || tick_b || db == '0) ? '0 : cb + DW'(1);
      if (load) begin
        per_act  <= per_we  ? per_wd    : per_sh;
        duty_act <= duty_we ? duty_wd   : duty_sh;
        mode_act <= mode_we ? center_wd : mode_sh;
      end
      if (idle) begin
        cnt  <= '0;
        down <= 1'b0;
      end else if (tick) begin
        cnt  <= nxt;
        down <= nxt_down;
      end
    end
  end
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    sel_r,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per_act,
  input logic [CW-1:0] duty_act,
  input logic          mode_act,
  input logic          pol_r,
  input logic          pwm_o,
  input logic          period_end_o
);
  p_left_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_act && per_act != '0) |-> cnt < per_act);

  p_center_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_act |-> cnt <= per_act);

  p_end_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_o |=> cnt == '0);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end_o && sel_r >= 4'd1 && sel_r <= 4'd10) |=> (!period_end_o || !$stable(sel_r)));

  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end_o && per_act != '0) |=> ($stable(per_act) && $stable(duty_act) && $stable(mode_act)));

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_r >= 4'd13 && per_act != '0) |=> $stable(cnt));

  p_zero_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> (pwm_o == pol_r));
endmodule

bind pwm_chan_core pwm_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_r(sel_r), .cnt(cnt), .per_act(per_act),
  .duty_act(duty_act), .mode_act(mode_act), .pol_r(pol_r), .pwm_o(pwm_o),
  .period_end_o(period_end_o)
);

// File: tb/test_pwm_chan_core.sv
`timescale 1ns/1ps
module test_pwm_chan_core;
  logic clk = 0, rst_n = 0;
  logic sel_we = 0, diva_we = 0, divb_we = 0, per_we = 0, duty_we = 0, mode_we = 0, pol_we = 0;
  logic [3:0] sel_wd = 0;
  logic [7:0] div_wd = 0;
  logic [15:0] per_wd = 0, duty_wd = 0;
  logic center_wd = 0, pol_wd = 0;
  logic pwm_o, period_end_o;

  int n_cmp = 0, n_bad = 0;
  string req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  pwm_chan_core i_pwm_chan_core (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wd(sel_wd), .diva_we(diva_we),
    .divb_we(divb_we), .div_wd(div_wd), .per_we(per_we), .per_wd(per_wd),
    .duty_we(duty_we), .duty_wd(duty_wd), .mode_we(mode_we), .center_wd(center_wd),
    .pol_we(pol_we), .pol_wd(pol_wd), .pwm_o(pwm_o), .period_end_o(period_end_o));

  // behavioural reference
  int m_pre, m_ca, m_cb, m_sel, m_da, m_db, m_psh, m_dsh, m_pact, m_dact, m_cnt;
  bit m_msh, m_mact, m_pol, m_down;

  function automatic bit m_tick();
    if (m_sel <= 10) return (m_pre % (1 << m_sel)) == (1 << m_sel) - 1;
    if (m_sel == 11) return m_da != 0 && m_ca == m_da - 1;
    if (m_sel == 12) return m_db != 0 && m_cb == m_db - 1;
    return 0;
  endfunction

  function automatic int m_step(output bit nd);
    nd = 0;
    if (m_pact == 0) return 0;
    if (!m_mact) return (m_cnt + 1 == m_pact) ? 0 : m_cnt + 1;
    if (m_down || m_cnt == m_pact) begin
      nd = (m_cnt - 1) != 0;
      return m_cnt - 1;
    end
    return m_cnt + 1;
  endfunction

  function automatic bit m_end();
    bit nd;
    return m_tick() && m_pact != 0 && m_step(nd) == 0;
  endfunction

  function automatic bit m_pwm();
    bit a = (m_dact != 0) && (m_dact >= m_pact || m_cnt < m_dact);
    return a ^ m_pol;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_ca = 0; m_cb = 0; m_sel = 0; m_da = 0; m_db = 0; m_psh = 0; m_dsh = 0;
      m_pact = 0; m_dact = 0; m_cnt = 0; m_msh = 0; m_mact = 0; m_pol = 0; m_down = 0;
    end else begin
      bit t, e, ta, tb, nd, idle;
      int nc;
      t = m_tick(); e = m_end(); nc = m_step(nd);
      ta = m_da != 0 && m_ca == m_da - 1;
      tb = m_db != 0 && m_cb == m_db - 1;
      idle = (m_pact == 0);
      m_pre = (m_pre + 1) % 1024;
      m_ca = (diva_we || ta || m_da == 0) ? 0 : m_ca + 1;
      m_cb = (divb_we || tb || m_db == 0) ? 0 : m_cb + 1;
      if (idle) begin m_cnt = 0; m_down = 0; end
      else if (t) begin m_cnt = nc; m_down = nd; end
      if (e || idle) begin
        m_pact = per_we ? int'(per_wd) : m_psh;
        m_dact = duty_we ? int'(duty_wd) : m_dsh;
        m_mact = mode_we ? center_wd : m_msh;
      end
      if (sel_we) m_sel = sel_wd;
      if (diva_we) m_da = div_wd;
      if (divb_we) m_db = div_wd;
      if (per_we) m_psh = per_wd;
      if (duty_we) m_dsh = duty_wd;
      if (mode_we) m_msh = center_wd;
      if (pol_we) m_pol = pol_wd;
    end
  end

  task automatic check(string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("pwm_o", pwm_o, m_pwm());
    check("period_end_o", period_end_o, m_end());
  end

  task automatic run(int n); repeat (n) @(negedge clk); endtask
  task automatic w_sel(int v); sel_we = 1; sel_wd = 4'(v); @(negedge clk); sel_we = 0; endtask
  task automatic w_da(int v); diva_we = 1; div_wd = 8'(v); @(negedge clk); diva_we = 0; endtask
  task automatic w_db(int v); divb_we = 1; div_wd = 8'(v); @(negedge clk); divb_we = 0; endtask
  task automatic w_pd(int p, int d);
    per_we = 1; per_wd = 16'(p); duty_we = 1; duty_wd = 16'(d);
    @(negedge clk); per_we = 0; duty_we = 0;
  endtask
  task automatic w_mode(bit c); mode_we = 1; center_wd = c; @(negedge clk); mode_we = 0; endtask
  task automatic w_pol(bit p); pol_we = 1; pol_wd = p; @(negedge clk); pol_we = 0; endtask
  task automatic wait_end(); while (!period_end_o) @(negedge clk); endtask

  initial begin
    run(3);
    rst_n = 1;
    run(1);
    req = "R1";
    check("reset pwm_o", pwm_o, 1'b0);
    check("reset period_end_o", period_end_o, 1'b0);
    run(5);
    req = "R5"; w_pd(5, 2); run(40);
    req = "R2"; w_sel(2); run(100);
    w_pd(3, 1); w_sel(10); run(7000);
    w_sel(4); run(300);
    req = "R3"; w_da(3); w_sel(11); run(200);
    w_da(7); run(200); w_da(0); run(60);
    req = "R6"; w_db(5); w_sel(12); w_mode(1); w_pd(4, 2); run(400);
    w_pd(1, 1); run(100);
    req = "R4"; w_sel(13); run(50); w_sel(15); run(30);
    req = "R8"; w_sel(0); run(20); w_pol(1); run(30);
    req = "R7"; w_mode(0); w_pd(6, 0); run(40); w_pol(0); run(20);
    w_pd(6, 9); run(40); w_pd(6, 6); run(40);
    req = "R9"; w_pd(10, 4); run(3); w_pd(4, 3); run(30);
    wait_end(); w_pd(7, 5); run(40);
    wait_end(); w_mode(1); run(60);
    w_pd(0, 0); run(10); w_pd(3, 2); run(30);
    req = "R10"; w_sel(3); run(200);
    wait_end(); w_sel(0); run(30);
    wait_end(); w_sel(1); run(60);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL %s watchdog expired: actual=running expected=finished", req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule